// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Read Latency

This block is a two-port static memory. Each port has its own clock and its own registered access controls: an active-low select, an active-high select, a read/write line, an address and a write word. Both ports can reach every word at the same time. The default size is 1024 words of 9 bits so the block elaborates cheaply. The address width parameter scales it, and setting `ADDR_W` to 17 gives 128K words.

Each port has two asynchronous controls. `oeN*` gates whether the port drives its data, and `pipe*` picks how many clocks a read takes to reach the output. In flow-through mode (`pipe*` = 0) a word read at a clock edge is on the output during the cycle that follows. In pipelined mode (`pipe*` = 1) the word and its drive enable come one cycle later. The data bus is split into an input, an output and an output-enable per port, so the enclosing design can build its own tri-state pad.

When both ports touch the same word at the same edge and at least one of them writes, `collide` goes high for the following cycle. This flag assumes both clocks share their edges, and it is clocked by port A.

Top module: `dpram_sync`

## Requirements
- R1: A port is selected at a rising edge only when its `csN*` is 0 and its `cs*` is 1. With any other combination, a write on that edge stores nothing. In flow-through mode `doutEn*` is 0 in the following cycle.
- R2: A selected port with `rw*` = 0 stores `din*` at `addr*` on the edge. `doutEn*` is 0 for a write cycle.
- R3: `oeN*` = 1 forces `doutEn*` to 0 at once, without waiting for a clock. Returning it to 0 restores the enable without a clock.
- R4: In flow-through mode, a selected read (`rw*` = 1) at edge k puts the addressed word on `dout*` with `doutEn*` = 1 in the cycle after edge k.
- R5: In pipelined mode, the word and its enable appear one edge later than in R4. A deselected edge releases the output only after two deselected edges in a row.
- R6: `pipe*` is asynchronous and separate for each port. One port can run flow-through while the other runs pipelined.
- R7: A word written by one port at edge k is returned by a read on the other port at edge k+1.
- R8: If one port writes and the other reads the same address on the same edge, the reader gets the old word and `collide` is 1 in the next cycle.
- R9: If both ports write the same address on the same edge, `collide` is 1. The word keeps the value from the port that was not the last writer of that word before the edge.
- R10: `dout*` keeps the last word read, in both modes, across edges with no selected read. This holds while `doutEn*` is 0.
- R11: While `rstN` is 0, `doutEn*` and `collide` are 0 and `dout*` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| csNA | input | 1 | Port A select, active low |
| csA | input | 1 | Port A select, active high |
| rwA | input | 1 | Port A: 1 read, 0 write |
| oeNA | input | 1 | Port A asynchronous output enable, active low |
| pipeA | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | DATA_W | Port A write word |
| doutA | output | DATA_W | Port A read word |
| doutEnA | output | 1 | Port A drive enable for `doutA` |
| csNB | input | 1 | Port B select, active low |
| csB | input | 1 | Port B select, active high |
| rwB | input | 1 | Port B: 1 read, 0 write |
| oeNB | input | 1 | Port B asynchronous output enable, active low |
| pipeB | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | DATA_W | Port B write word |
| doutB | output | DATA_W | Port B read word |
| doutEnB | output | 1 | Port B drive enable for `doutB` |
| collide | output | 1 | Same-edge access to one word with at least one write |

## Verification
The bench drives the following patterns:
- **Back-to-back reads in each mode.** These show that the pipelined path lags the flow-through path by exactly one edge.
- **Both select pins deasserted, and write strobes on a deselected port.** These separate the two deselect encodings and show that nothing is stored.
- **A write on one port followed by a read on the other, first on the next edge and then on the same edge.** This tells new data apart from old data.
- **Two same-edge double writes in sequence.** These show that the surviving value alternates with the previous owner of the word.
- **Mid-cycle toggles of `oeN*` and `pipe*`.** These show that both act without a clock.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NUM_PORTS = 2;

  // Per-edge access strobes from a port's control to the datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } portStb_t;
endpackage

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     cs,
  input  logic     rw,
  input  logic     oeN,
  input  logic     pipe,
  output portStb_t stb,
  output logic     drvEn
);
  logic selNow;
  logic stage1Q;
  logic stage2Q;

  assign selNow = !csN && cs;
  assign stb.rd = selNow && rw;
  assign stb.wr = selNow && !rw;

  // Drive-enable pipeline: stage1 serves flow-through, stage2 serves pipelined
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
    end else begin
      stage1Q <= stb.rd;
      stage2Q <= stage1Q;
    end
  end

  assign drvEn = !oeN && (pipe ? stage2Q : stage1Q);

  a_r1_deselect_release: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> (pipe || !drvEn));

  a_r2_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |=> (pipe || !drvEn));

  a_r5_two_deselects: assert property (@(posedge clk) disable iff (!rstN)
    (!selNow && !stage1Q) |=> !drvEn);
endmodule

// File: rtl/dpram_data.sv
module dpram_data
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic [NUM_PORTS-1:0] clk,
  input  logic                 rstN,
  input  portStb_t             stb  [NUM_PORTS],
  input  logic [ADDR_W-1:0]    addr [NUM_PORTS],
  input  logic [DATA_W-1:0]    din  [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] pipe,
  output logic [DATA_W-1:0]    dout [NUM_PORTS],
  output logic                 collide
);
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writing port plus a last-writer tag pair per word:
  // equal tags mean bank A holds the live copy, unequal mean bank B.
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];
  logic [DEPTH-1:0]  tagA;
  logic [DEPTH-1:0]  tagB;

  function automatic logic [DATA_W-1:0] wordAt(input logic [ADDR_W-1:0] a);
    return (tagA[a] == tagB[a]) ? bankA[a] : bankB[a];
  endfunction

  always_ff @(posedge clk[0]) begin
    if (stb[0].wr) begin
      bankA[addr[0]] <= din[0];
      tagA[addr[0]]  <= tagB[addr[0]];
    end
  end

  always_ff @(posedge clk[1]) begin
    if (stb[1].wr) begin
      bankB[addr[1]] <= din[1];
      tagB[addr[1]]  <= ~tagA[addr[1]];
    end
  end

  logic sameWord;
  assign sameWord = (addr[0] == addr[1]);

  always_ff @(posedge clk[0] or negedge rstN) begin
    if (!rstN) collide <= 1'b0;
    else collide <= sameWord &&
                    ((stb[0].wr && (stb[1].rd || stb[1].wr)) || (stb[0].rd && stb[1].wr));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] rdQ;
    logic [DATA_W-1:0] pipeQ;

    always_ff @(posedge clk[p] or negedge rstN) begin
      if (!rstN) begin
        rdQ   <= '0;
        pipeQ <= '0;
      end else begin
        if (stb[p].rd) rdQ <= wordAt(addr[p]);
        pipeQ <= rdQ;
      end
    end

    assign dout[p] = pipe[p] ? pipeQ : rdQ;

    a_r10_hold_word: assert property (@(posedge clk[p]) disable iff (!rstN)
      !stb[p].rd |=> $stable(rdQ));

    a_r5_pipe_lag: assert property (@(posedge clk[p]) disable iff (!rstN)
      !$stable(rdQ) |=> (pipeQ == $past(rdQ)));
  end

  a_r2_word_stored: assert property (@(posedge clk[0]) disable iff (!rstN)
    (stb[0].wr && !(stb[1].wr && sameWord)) |=> (wordAt($past(addr[0])) == $past(din[0])));
endmodule

// File: rtl/dpram_sync.sv
module dpram_sync
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              csNA,
  input  logic              csA,
  input  logic              rwA,
  input  logic              oeNA,
  input  logic              pipeA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  output logic [DATA_W-1:0] doutA,
  output logic              doutEnA,
  input  logic              csNB,
  input  logic              csB,
  input  logic              rwB,
  input  logic              oeNB,
  input  logic              pipeB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutB,
  output logic              doutEnB,
  output logic              collide
);
  logic [NUM_PORTS-1:0] clkV, csNV, csV, rwV, oeNV, pipeV, drvV;
  logic [ADDR_W-1:0]    addrV [NUM_PORTS];
  logic [DATA_W-1:0]    dinV  [NUM_PORTS];
  logic [DATA_W-1:0]    doutV [NUM_PORTS];
  portStb_t             stbV  [NUM_PORTS];

  assign clkV  = {clkB, clkA};
  assign csNV  = {csNB, csNA};
  assign csV   = {csB, csA};
  assign rwV   = {rwB, rwA};
  assign oeNV  = {oeNB, oeNA};
  assign pipeV = {pipeB, pipeA};
  assign addrV[0] = addrA;
  assign addrV[1] = addrB;
  assign dinV[0]  = dinA;
  assign dinV[1]  = dinB;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ctrl
    dpram_ctrl u_ctrl (
      .clk  (clkV[p]),
      .rstN (rstN),
      .csN  (csNV[p]),
      .cs   (csV[p]),
      .rw   (rwV[p]),
      .oeN  (oeNV[p]),
      .pipe (pipeV[p]),
      .stb  (stbV[p]),
      .drvEn(drvV[p])
    );
  end

  dpram_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk    (clkV),
    .rstN   (rstN),
    .stb    (stbV),
    .addr   (addrV),
    .din    (dinV),
    .pipe   (pipeV),
    .dout   (doutV),
    .collide(collide)
  );

  assign doutA   = doutV[0];
  assign doutB   = doutV[1];
  assign doutEnA = drvV[0];
  assign doutEnB = drvV[1];
endmodule

// File: tb/dpram_sync_bench.sv
module dpram_sync_bench;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csNA = 1'b1, csA = 1'b0, rwA = 1'b1, oeNA = 1'b0, pipeA = 1'b0;
  logic csNB = 1'b1, csB = 1'b0, rwB = 1'b1, oeNB = 1'b0, pipeB = 1'b0;
  logic [AW-1:0] addrA = '0, addrB = '0;
  logic [DW-1:0] dinA = '0, dinB = '0;
  logic [DW-1:0] doutA, doutB;
  logic doutEnA, doutEnB, collide;

  always #4 clk = ~clk;

  dpram_sync #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_sync (
    .clkA(clk), .clkB(clk), .rstN(rstN),
    .csNA(csNA), .csA(csA), .rwA(rwA), .oeNA(oeNA), .pipeA(pipeA),
    .addrA(addrA), .dinA(dinA), .doutA(doutA), .doutEnA(doutEnA),
    .csNB(csNB), .csB(csB), .rwB(rwB), .oeNB(oeNB), .pipeB(pipeB),
    .addrB(addrB), .dinB(dinB), .doutB(doutB), .doutEnB(doutEnB),
    .collide(collide)
  );

  int checks = 0;
  int fails = 0;
  string curTag = "R11";

  // Behavioural reference model
  int mMem [DEPTH];
  int mOwn [DEPTH];
  int mRd1 [2];
  int mRd2 [2];
  bit mSt1 [2];
  bit mSt2 [2];
  bit mCol;
  bit rA, wA, rB, wB;
  int nA, nB;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        mRd1[p] = 0; mRd2[p] = 0; mSt1[p] = 0; mSt2[p] = 0;
      end
      mCol = 0;
    end else begin
      rA = !csNA && csA && rwA;  wA = !csNA && csA && !rwA;
      rB = !csNB && csB && rwB;  wB = !csNB && csB && !rwB;
      nA = rA ? mMem[addrA] : mRd1[0];
      nB = rB ? mMem[addrB] : mRd1[1];
      mCol = (addrA == addrB) && ((wA && (rB || wB)) || (rA && wB));
      if (wA && wB && addrA == addrB) begin
        if (mOwn[addrA] == 0) begin mMem[addrA] = int'(dinB); mOwn[addrA] = 1; end
        else begin mMem[addrA] = int'(dinA); mOwn[addrA] = 0; end
      end else begin
        if (wA) begin mMem[addrA] = int'(dinA); mOwn[addrA] = 0; end
        if (wB) begin mMem[addrB] = int'(dinB); mOwn[addrB] = 1; end
      end
      for (int p = 0; p < 2; p++) begin
        mRd2[p] = mRd1[p];
        mSt2[p] = mSt1[p];
      end
      mRd1[0] = nA; mRd1[1] = nB;
      mSt1[0] = rA; mSt1[1] = rB;
    end
  end

  function automatic bit expEn(input int p);
    bit oe = (p == 0) ? oeNA : oeNB;
    bit pm = (p == 0) ? pipeA : pipeB;
    return !oe && (pm ? mSt2[p] : mSt1[p]);
  endfunction

  function automatic int expDout(input int p);
    bit pm = (p == 0) ? pipeA : pipeB;
    return pm ? mRd2[p] : mRd1[p];
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", curTag, what, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check(doutEnA == expEn(0), "doutEnA", int'(doutEnA), int'(expEn(0)));
    check(int'(doutA) == expDout(0), "doutA", int'(doutA), expDout(0));
    check(doutEnB == expEn(1), "doutEnB", int'(doutEnB), int'(expEn(1)));
    check(int'(doutB) == expDout(1), "doutB", int'(doutB), expDout(1));
    check(collide == mCol, "collide", int'(collide), int'(mCol));
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic opA(input bit s, input bit r, input int a, input int d);
    csNA = !s; csA = s; rwA = r; addrA = AW'(a); dinA = DW'(d);
  endtask

  task automatic opB(input bit s, input bit r, input int a, input int d);
    csNB = !s; csB = s; rwB = r; addrB = AW'(a); dinB = DW'(d);
  endtask

  initial begin
    // R11: reset holds outputs quiet
    repeat (3) step();
    rstN = 1'b1;
    step();

    curTag = "R2";
    opA(1, 0, 'h10, 'h1A5); opB(1, 0, 'h21, 'h033); step();
    opA(1, 0, 'h11, 'h0F3); opB(0, 1, 0, 0); step();
    opA(1, 0, 'h12, 'h100); step();
    opA(1, 0, 'h13, 'h07E); step();

    curTag = "R4";
    opA(1, 1, 'h10, 0); opB(1, 1, 'h12, 0); step();
    opA(1, 1, 'h11, 0); opB(1, 1, 'h13, 0); step();

    curTag = "R1";
    opB(0, 1, 0, 0);
    csNA = 1'b1; csA = 1'b1; rwA = 1'b0; addrA = 'h10; dinA = 'h1FF; step();
    csNA = 1'b0; csA = 1'b0; step();
    csNA = 1'b1; csA = 1'b0; step();
    opA(1, 1, 'h10, 0); step();

    curTag = "R10";
    opA(0, 1, 0, 0); step(); step();

    curTag = "R3";
    opA(1, 1, 'h11, 0); step();
    oeNA = 1'b1; #1;
    check(doutEnA == 1'b0, "doutEnA async off", int'(doutEnA), 0);
    oeNA = 1'b0; #1;
    check(doutEnA == 1'b1 && doutA == 9'h0F3, "doutA async on", int'(doutA), 'h0F3);
    oeNA = 1'b1; step();
    oeNA = 1'b0;

    curTag = "R5";
    pipeA = 1'b1;
    opA(1, 1, 'h10, 0); step();
    opA(1, 1, 'h11, 0); step();
    opA(1, 1, 'h12, 0); step();
    opA(0, 1, 0, 0); step(); step(); step();

    curTag = "R6";
    opA(1, 1, 'h13, 0); opB(1, 1, 'h10, 0); step();
    opA(0, 1, 0, 0); opB(0, 1, 0, 0);
    check(doutEnB == 1'b1 && doutB == 9'h1A5, "doutB flow beside piped A", int'(doutB), 'h1A5);
    step();
    pipeA = 1'b0; #1;
    check(doutEnA == 1'b0, "doutEnA after async mode flip", int'(doutEnA), 0);
    step();

    curTag = "R7";
    opA(1, 0, 'h20, 'h155); step();
    opA(0, 1, 0, 0); opB(1, 1, 'h20, 0); step();
    check(doutB == 9'h155, "doutB cross-port read", int'(doutB), 'h155);
    opB(0, 1, 0, 0); step();

    curTag = "R8";
    opA(1, 0, 'h21, 'h0AA); opB(1, 1, 'h21, 0); step();
    check(collide == 1'b1 && doutB == 9'h033, "old word on collision", int'(doutB), 'h033);
    opA(0, 1, 0, 0); step();
    check(doutB == 9'h0AA, "doutB new word", int'(doutB), 'h0AA);
    opB(0, 1, 0, 0); step();

    curTag = "R9";
    opA(1, 0, 'h22, 'h0FF); step();
    opA(1, 0, 'h22, 'h111); opB(1, 0, 'h22, 'h0CC); step();
    check(collide == 1'b1, "collide double write", int'(collide), 1);
    opA(1, 1, 'h22, 0); opB(0, 1, 0, 0); step();
    check(doutA == 9'h0CC, "port B wins over last writer A", int'(doutA), 'h0CC);
    opA(1, 0, 'h22, 'h1E1); opB(1, 0, 'h22, 'h01E); step();
    opA(1, 1, 'h22, 0); opB(0, 1, 0, 0); step();
    check(doutA == 9'h1E1, "port A wins over last writer B", int'(doutA), 'h1E1);
    opA(0, 1, 0, 0); step(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired (%s) actual=%0d expected=%0d", curTag, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule